// File: doc/BRIEF.md
# Pattern Generator and Error-Rate Checker

This block sits on one port's serial path and measures the bit error rate of that link. The transmit half produces one pattern bit for every cycle in which its enable is high. The pattern is either a pseudo-random sequence built from two taps of a history of up to 32 bits, or a fixed word of 1 to 32 bits repeated without end. Both come from a seed word applied once after reset. Errors can be added to the transmit stream, either one bit on request or one bit every 10^k bits.

The receive half takes one bit for every cycle in which its enable is high and can invert the stream first. It runs a three-state machine:
- ST_LOAD fills the prediction history with 32 received bits, then moves to ST_VERIFY.
- ST_VERIFY checks 32 predicted bits. Any mismatch goes back to ST_LOAD. Thirty-two clean bits go on to ST_SYNC.
- ST_SYNC counts mismatches. It drops back to ST_LOAD when the error density becomes too high.
- A rising edge on the manual resync input forces ST_LOAD from any state.

The received-bit and error counts run live and saturate. A rising edge on the update input copies them to held outputs and clears the live counters.

Top module: `bert_core`

## Requirements
- R1: After reset, in_sync, pm_done, tx_bit, bit_cnt and err_cnt are all 0.
- R2: The pattern history h starts as pat_seed, with bit 0 the most recent bit. Each tx_en cycle produces b = h[pat_len] ^ (pat_prbs & h[pat_tap]) and shifts b into bit 0. tx_bit shows b after that clock edge. The seed is taken in the first cycle after reset. tx_en is ignored in that cycle.
- R3: From ST_LOAD, in_sync rises after exactly 64 received bits of a valid stream: 32 loaded and 32 verified. A mismatch during verification restarts loading.
- R4: A rising edge of resync drops in_sync in the next cycle and restarts acquisition.
- R5: When rx_inv is 1, every received bit is inverted before it is used. An inverted line stream then synchronizes with no errors.
- R6: In ST_SYNC, the 6th error within any 64 consecutive received bits drops in_sync after that bit. Five errors in such a window keep sync.
- R7: err_cnt counts only mismatches found in ST_SYNC, including the one that causes loss. bit_cnt counts every received bit. Both counters saturate at all ones.
- R8: A rising edge of pm_upd loads bit_cnt and err_cnt with the live counts, including any bit taken in that same cycle, and clears the live counts. pm_done is 1 from the next cycle until pm_upd falls.
- R9: A rising edge of inj_single inverts exactly the next generated bit.
- R10: When inj_rate = k (1..7), every 10^k-th generated bit counted from the last idle state is inverted. k = 0 injects nothing and rearms the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_prbs | input | 1 | 1 selects pseudo-random, 0 selects repeating word |
| pat_len | input | 5 | Pattern length minus one |
| pat_tap | input | 5 | Second feedback tap minus one (pseudo-random only) |
| pat_seed | input | 32 | Seed history, or the repeating word |
| tx_en | input | 1 | Produce one transmit bit this cycle |
| tx_bit | output | 1 | Generated bit |
| inj_single | input | 1 | Rising edge inserts one error |
| inj_rate | input | 3 | Continuous insertion rate code |
| rx_en | input | 1 | rx_bit is valid this cycle |
| rx_bit | input | 1 | Received bit |
| rx_inv | input | 1 | Invert received data |
| resync | input | 1 | Rising edge forces reacquisition |
| pm_upd | input | 1 | Rising edge snapshots the counters |
| pm_done | output | 1 | Snapshot taken, held while pm_upd is high |
| in_sync | output | 1 | Checker is in ST_SYNC |
| bit_cnt | output | BIT_W | Held received-bit count |
| err_cnt | output | ERR_W | Held error count |

## Verification
Results are due at the following points:
- tx_bit and in_sync are registered. They are due one edge after the enabling or offending bit.
- The held counters and pm_done are due one edge after the pm_upd rise.

The bench changes inputs on the falling edge and samples just before the next falling edge, so each result is read exactly one rising edge after its cause. Sync acquisition is checked at bit 63 (still 0) and bit 64 (now 1). Loss is checked after the 5th and after the 6th error in a window. Injected errors are located by comparing tx_bit bit by bit with the bench's own pattern model.

// File: rtl/bert_pkg.sv
package bert_pkg;

    localparam int HIST_W = 32;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_SYNC   = 2'd2
    } chk_state_t;

    // Next pattern bit predicted from history (bit 0 = newest).
    function automatic logic pat_predict(input logic [HIST_W-1:0] h,
                                         input logic              prbs,
                                         input logic [4:0]        len,
                                         input logic [4:0]        tap);
        return h[len] ^ (prbs & h[tap]);
    endfunction

    // Bits between inserted errors for a rate code.
    function automatic logic [23:0] rate_period(input logic [2:0] code);
        logic [23:0] r;
        r = 24'd1;
        for (int i = 1; i < 8; i++) begin
            if (i <= int'(code)) r = r * 24'd10;
        end
        return r;
    endfunction

endpackage

// File: rtl/bert_satcnt.sv
module bert_satcnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         snap,
    output logic [W-1:0] hold
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] live_q;
    logic [W-1:0] live_nxt;

    always_comb begin
        live_nxt = (live_q == MAXV) ? live_q : live_q + W'(inc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            hold   <= '0;
        end else if (snap) begin
            hold   <= live_nxt;
            live_q <= '0;
        end else begin
            live_q <= live_nxt;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == MAXV && !snap) |=> (live_q == MAXV)); // R7

    AST_SNAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (live_q == '0)); // R8

endmodule

// File: rtl/bert_txgen.sv
module bert_txgen (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_en,
    input  logic        pat_prbs,
    input  logic [4:0]  pat_len,
    input  logic [4:0]  pat_tap,
    input  logic [31:0] pat_seed,
    input  logic        inj_single,
    input  logic [2:0]  inj_rate,
    output logic        tx_bit
);
    import bert_pkg::*;

    localparam int RCW = 24;

    logic              seeded_q;
    logic [HIST_W-1:0] hist_q;
    logic              bit_q;
    logic              pend_q;
    logic              inj_q;
    logic [RCW-1:0]    rc_q;

    logic              rise;
    logic              pred;
    logic [RCW-1:0]    limit;
    logic              rate_hit;
    logic              flip;

    always_comb begin
        rise     = inj_single && !inj_q;
        pred     = pat_predict(hist_q, pat_prbs, pat_len, pat_tap);
        limit    = rate_period(inj_rate);
        rate_hit = (inj_rate != 3'd0) && (rc_q >= limit - RCW'(1));
        flip     = pend_q || rise || rate_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seeded_q <= 1'b0;
            hist_q   <= '0;
            bit_q    <= 1'b0;
            pend_q   <= 1'b0;
            inj_q    <= 1'b0;
            rc_q     <= '0;
        end else begin
            inj_q <= inj_single;
            if (!seeded_q) begin
                seeded_q <= 1'b1;
                hist_q   <= pat_seed;
                pend_q   <= pend_q || rise;
            end else begin
                pend_q <= (pend_q || rise) && !tx_en;
                if (tx_en) begin
                    hist_q <= {hist_q[HIST_W-2:0], pred};
                    bit_q  <= pred ^ flip;
                end
                if (inj_rate == 3'd0)
                    rc_q <= '0;
                else if (tx_en)
                    rc_q <= rate_hit ? '0 : rc_q + RCW'(1);
            end
        end
    end

    assign tx_bit = bit_q;

    AST_INJ_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (seeded_q && tx_en && pend_q) |=> !pend_q); // R9

    AST_RATE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (seeded_q && tx_en && inj_rate != 3'd0) |=> (rc_q < $past(limit))); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seeded_q && !tx_en) |=> $stable(tx_bit)); // R2

endmodule

// File: rtl/bert_rxchk.sv
module bert_rxchk #(
    parameter int WIN    = 64,
    parameter int LOSS   = 6,
    parameter int LOAD_N = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       rx_bit,
    input  logic       rx_inv,
    input  logic       resync,
    input  logic       pat_prbs,
    input  logic [4:0] pat_len,
    input  logic [4:0] pat_tap,
    output logic       in_sync,
    output logic       err_inc
);
    import bert_pkg::*;

    localparam int CW = $clog2(LOAD_N);
    localparam logic [CW-1:0] LAST = CW'(LOAD_N - 1);
    localparam int EW = WIN - 1;

    chk_state_t        state_q, state_d;
    logic [HIST_W-1:0] hist_q,  hist_d;
    logic [CW-1:0]     cnt_q,   cnt_d;
    logic [EW-1:0]     ehist_q, ehist_d;
    logic              resync_q;

    logic d_bit, pred, mism, rs_rise;
    int   win_errs;

    always_comb begin
        d_bit    = rx_bit ^ rx_inv;
        pred     = pat_predict(hist_q, pat_prbs, pat_len, pat_tap);
        mism     = d_bit != pred;
        rs_rise  = resync && !resync_q;
        win_errs = $countones(ehist_q) + int'(mism);
        state_d  = state_q;
        hist_d   = hist_q;
        cnt_d    = cnt_q;
        ehist_d  = ehist_q;
        if (rs_rise) begin
            state_d = ST_LOAD;
            cnt_d   = '0;
            ehist_d = '0;
        end else if (rx_en) begin
            unique case (state_q)
                ST_LOAD: begin
                    hist_d = {hist_q[HIST_W-2:0], d_bit};
                    if (cnt_q == LAST) begin
                        state_d = ST_VERIFY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_VERIFY: begin
                    hist_d = {hist_q[HIST_W-2:0], pred};
                    if (mism) begin
                        state_d = ST_LOAD;
                        cnt_d   = '0;
                    end else if (cnt_q == LAST) begin
                        state_d = ST_SYNC;
                        cnt_d   = '0;
                        ehist_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_SYNC: begin
                    hist_d  = {hist_q[HIST_W-2:0], pred};
                    ehist_d = {ehist_q[EW-2:0], mism};
                    if (win_errs >= LOSS) begin
                        state_d = ST_LOAD;
                        cnt_d   = '0;
                        ehist_d = '0;
                    end
                end
                default: state_d = ST_LOAD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_LOAD;
            hist_q   <= '0;
            cnt_q    <= '0;
            ehist_q  <= '0;
            resync_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            hist_q   <= hist_d;
            cnt_q    <= cnt_d;
            ehist_q  <= ehist_d;
            resync_q <= resync;
        end
    end

    always_comb begin
        in_sync = (state_q == ST_SYNC);
        err_inc = rx_en && !rs_rise && (state_q == ST_SYNC) && mism;
    end

    AST_SYNC_VIA_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && $past(state_q) != ST_SYNC) |-> ($past(state_q) == ST_VERIFY)); // R3

    AST_RESYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resync) |=> (state_q == ST_LOAD)); // R4

    AST_LOSS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && rx_en && win_errs >= LOSS) |=> !in_sync); // R6

    AST_ERR_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        err_inc |-> in_sync); // R7

endmodule

// File: rtl/bert_core.sv
module bert_core #(
    parameter int BIT_W = 32,
    parameter int ERR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pat_prbs,
    input  logic [4:0]       pat_len,
    input  logic [4:0]       pat_tap,
    input  logic [31:0]      pat_seed,
    input  logic             tx_en,
    output logic             tx_bit,
    input  logic             inj_single,
    input  logic [2:0]       inj_rate,
    input  logic             rx_en,
    input  logic             rx_bit,
    input  logic             rx_inv,
    input  logic             resync,
    input  logic             pm_upd,
    output logic             pm_done,
    output logic             in_sync,
    output logic [BIT_W-1:0] bit_cnt,
    output logic [ERR_W-1:0] err_cnt
);
    logic pm_q;
    logic pm_rise;
    logic err_inc;

    assign pm_rise = pm_upd && !pm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_q    <= 1'b0;
            pm_done <= 1'b0;
        end else begin
            pm_q    <= pm_upd;
            pm_done <= pm_upd && (pm_done || !pm_q);
        end
    end

    bert_txgen u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .pat_prbs   (pat_prbs),
        .pat_len    (pat_len),
        .pat_tap    (pat_tap),
        .pat_seed   (pat_seed),
        .inj_single (inj_single),
        .inj_rate   (inj_rate),
        .tx_bit     (tx_bit)
    );

    bert_rxchk u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .rx_bit   (rx_bit),
        .rx_inv   (rx_inv),
        .resync   (resync),
        .pat_prbs (pat_prbs),
        .pat_len  (pat_len),
        .pat_tap  (pat_tap),
        .in_sync  (in_sync),
        .err_inc  (err_inc)
    );

    bert_satcnt #(.W(BIT_W)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rx_en),
        .snap  (pm_rise),
        .hold  (bit_cnt)
    );

    bert_satcnt #(.W(ERR_W)) u_errs (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err_inc),
        .snap  (pm_rise),
        .hold  (err_cnt)
    );

    AST_PM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pm_upd) |=> pm_done); // R8

    AST_PM_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_upd |=> !pm_done); // R8

endmodule

// File: tb/bert_core_tb.sv
module bert_core_tb;
    localparam int CLK_P = 10;
    localparam int EW    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pat_prbs = 1'b1;
    logic [4:0]  pat_len = 5'd6;
    logic [4:0]  pat_tap = 5'd5;
    logic [31:0] pat_seed = 32'h5A;
    logic        tx_en = 1'b0;
    logic        tx_bit;
    logic        inj_single = 1'b0;
    logic [2:0]  inj_rate = 3'd0;
    logic        rx_en = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_inv = 1'b0;
    logic        resync = 1'b0;
    logic        pm_upd = 1'b0;
    logic        pm_done;
    logic        in_sync;
    logic [31:0] bit_cnt;
    logic [EW-1:0] err_cnt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] tx_h;
    logic [31:0] rx_h;
    int nbits = 0;

    always #(CLK_P/2) clk = ~clk;

    bert_core #(.BIT_W(32), .ERR_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pat_prbs(pat_prbs), .pat_len(pat_len),
        .pat_tap(pat_tap), .pat_seed(pat_seed), .tx_en(tx_en), .tx_bit(tx_bit),
        .inj_single(inj_single), .inj_rate(inj_rate), .rx_en(rx_en),
        .rx_bit(rx_bit), .rx_inv(rx_inv), .resync(resync), .pm_upd(pm_upd),
        .pm_done(pm_done), .in_sync(in_sync), .bit_cnt(bit_cnt), .err_cnt(err_cnt)
    );

    function automatic logic model_bit(input logic [31:0] h);
        return h[pat_len] ^ (pat_prbs & h[pat_tap]);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic prbs, input logic [4:0] len,
                            input logic [4:0] tap, input logic [31:0] seed);
        pat_prbs = prbs; pat_len = len; pat_tap = tap; pat_seed = seed;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        tx_h = seed;
        rx_h = seed;
        nbits = 0;
    endtask

    task automatic send_rx(input bit flip);
        logic b;
        b = model_bit(rx_h);
        rx_h = {rx_h[30:0], b};
        rx_bit = b ^ flip ^ rx_inv;
        rx_en = 1'b1;
        @(negedge clk);
        rx_en = 1'b0;
        nbits++;
    endtask

    task automatic pm_snap(input string req, input int exp_err);
        pm_upd = 1'b1;
        @(negedge clk);
        chk(bit_cnt == 32'(nbits), {req, " bit_cnt"}, bit_cnt, nbits);
        chk(err_cnt == EW'(exp_err), {req, " err_cnt"}, err_cnt, exp_err);
        chk(pm_done == 1'b1, "R8 pm_done set", pm_done, 1);
        pm_upd = 1'b0;
        @(negedge clk);
        chk(pm_done == 1'b0, "R8 pm_done clear", pm_done, 0);
        nbits = 0;
    endtask

    task automatic tx_run(input int n, output int mism, output int first);
        logic b;
        mism = 0;
        first = -1;
        for (int i = 0; i < n; i++) begin
            b = model_bit(tx_h);
            tx_h = {tx_h[30:0], b};
            tx_en = 1'b1;
            @(negedge clk);
            tx_en = 1'b0;
            if (tx_bit !== b) begin
                mism++;
                if (first < 0) first = i;
            end
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int mism;
        int first;
        int flips;
        logic [63:0] fw;
        bit f;
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset(1'b1, 5'd6, 5'd5, 32'h5A);
        // R1 reset state
        chk(in_sync == 1'b0, "R1 in_sync", in_sync, 0);
        chk(pm_done == 1'b0, "R1 pm_done", pm_done, 0);
        chk(tx_bit == 1'b0, "R1 tx_bit", tx_bit, 0);
        chk(bit_cnt == 0, "R1 bit_cnt", bit_cnt, 0);
        chk(err_cnt == 0, "R1 err_cnt", err_cnt, 0);

        // R2 pseudo-random transmit, R10 rate 0 injects nothing
        tx_run(200, mism, first);
        chk(mism == 0, "R2 R10 prbs tx mismatches", mism, 0);

        // R3 acquisition timing
        for (int i = 0; i < 63; i++) send_rx(1'b0);
        chk(in_sync == 1'b0, "R3 not in sync at bit 63", in_sync, 0);
        send_rx(1'b0);
        chk(in_sync == 1'b1, "R3 in sync at bit 64", in_sync, 1);
        pm_snap("R7 R8 acquisition", 0);

        // R6 five errors in a window keep sync
        for (int i = 0; i < 100; i++) send_rx(i >= 10 && i <= 50 && (i % 10) == 0);
        chk(in_sync == 1'b1, "R6 five errors keep sync", in_sync, 1);
        pm_snap("R7 five errors", 5);

        // R6 sixth error in window drops sync; R7 no count while out
        for (int i = 0; i < 70; i++) send_rx(1'b0);
        for (int i = 0; i < 25; i++) send_rx((i % 5) == 0);
        chk(in_sync == 1'b1, "R6 sync after fifth", in_sync, 1);
        send_rx(1'b1);
        chk(in_sync == 1'b0, "R6 loss after sixth", in_sync, 0);
        for (int i = 0; i < 20; i++) send_rx(1'b1);
        pm_snap("R7 loss", 6);

        // R3 recovery after corrupted load, verify mismatches not counted
        for (int i = 0; i < 200; i++) send_rx(1'b0);
        chk(in_sync == 1'b1, "R3 reacquired", in_sync, 1);
        pm_snap("R7 reacquire", 0);

        // R4 manual resync
        resync = 1'b1;
        @(negedge clk);
        chk(in_sync == 1'b0, "R4 resync drops sync", in_sync, 0);
        resync = 1'b0;
        for (int i = 0; i < 63; i++) send_rx(1'b0);
        chk(in_sync == 1'b0, "R4 R3 bit 63 after resync", in_sync, 0);
        send_rx(1'b0);
        chk(in_sync == 1'b1, "R4 R3 bit 64 after resync", in_sync, 1);

        // R5 inverted line
        rx_inv = 1'b1;
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        for (int i = 0; i < 64; i++) send_rx(1'b0);
        chk(in_sync == 1'b1, "R5 inverted stream syncs", in_sync, 1);
        pm_snap("R5 inverted", 0);
        for (int i = 0; i < 100; i++) send_rx(1'b0);
        pm_snap("R5 inverted clean", 0);

        // R7 saturation: 35 errors, 4-bit counter
        for (int i = 0; i < 700; i++) send_rx((i % 20) == 19);
        chk(in_sync == 1'b1, "R7 sync during saturation run", in_sync, 1);
        pm_snap("R7 saturate", 15);

        // R6 R7 random sparse errors
        for (int i = 0; i < 70; i++) send_rx(1'b0);
        pm_snap("R7 gap", 0);
        fw = '0;
        flips = 0;
        for (int i = 0; i < 3000; i++) begin
            f = (($urandom % 100) == 0) && ($countones(fw[62:0]) < 5);
            fw = {fw[62:0], f};
            if (f) flips++;
            send_rx(f);
        end
        chk(in_sync == 1'b1, "R6 random sparse keeps sync", in_sync, 1);
        pm_snap("R7 random", (flips > 15) ? 15 : flips);

        // R9 single insertion
        inj_single = 1'b1;
        @(negedge clk);
        inj_single = 1'b0;
        @(negedge clk);
        tx_run(50, mism, first);
        chk(mism == 1, "R9 one flip", mism, 1);
        chk(first == 0, "R9 flip position", first, 0);

        // R10 rate code 1 and 2
        inj_rate = 3'd1;
        tx_run(100, mism, first);
        chk(mism == 10, "R10 code1 count", mism, 10);
        chk(first == 9, "R10 code1 first", first, 9);
        inj_rate = 3'd0;
        @(negedge clk);
        inj_rate = 3'd2;
        tx_run(300, mism, first);
        chk(mism == 3, "R10 code2 count", mism, 3);
        chk(first == 99, "R10 code2 first", first, 99);
        inj_rate = 3'd0;
        @(negedge clk);

        // R2 R3 R6 repeating 12-bit word
        rx_inv = 1'b0;
        do_reset(1'b0, 5'd11, 5'd0, 32'hABC);
        tx_run(60, mism, first);
        chk(mism == 0, "R2 repeating tx", mism, 0);
        for (int i = 0; i < 64; i++) send_rx(1'b0);
        chk(in_sync == 1'b1, "R3 repeating sync", in_sync, 1);
        for (int i = 0; i < 5; i++) send_rx(1'b1);
        chk(in_sync == 1'b1, "R6 repeating five errors", in_sync, 1);
        send_rx(1'b1);
        chk(in_sync == 1'b0, "R6 repeating mismatch drops", in_sync, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule